// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block turns one display auxiliary-channel request into the byte stream a serializer sends, and turns the reply bytes that come back into a status nibble, an ordered stream of data bytes and a completion code. The requester gives a 4-bit command, a 20-bit address, a length and, for write commands, a payload, and pulses `start`. The block latches these fields and sends the header and payload over a valid/ready byte interface. It then accepts the reply from the receiver over a byte-strobe interface that has an end-of-reply marker. Line coding, sync patterns, channel arbitration and retry policy are handled by other blocks.

Native and I2C-tunnelled commands use the same framing. A command nibble of 4'h8 (native write), 4'h0 (I2C write) or 4'h4 (I2C write, transaction kept open) is a write and carries a payload. Every other nibble is treated as a read or status request and carries no payload. A length of zero gives an address-only request.

Top module: `aux_xact_engine`

## Requirements
- R1: The first transmitted byte is {cmd[3:0], addr[19:16]}. The second is addr[15:8] and the third is addr[7:0].
- R2: For a nonzero length, a fourth header byte equal to length-1 follows the address. For a zero length, the header ends after three bytes.
- R3: For write commands (4'h8, 4'h0, 4'h4), the header is followed by `length` payload bytes, with byte i taken from wr_data[8*i+7:8*i] in increasing i. Any other command sends only the header.
- R4: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value in the next cycle.
- R5: reply_status shows bits [7:4] of the first reply byte. If that nibble is 0 (ACK), the following reply bytes appear in order on out_data with out_valid, one cycle after each is received. If it is nonzero, no byte is forwarded and done_code is 0 (OK).
- R6: A reply that ends (rx_end) before any byte was received completes with done_code 1 (invalid reply).
- R7: If an ACK reply carries more data bytes than the request length, only the first `length` bytes are forwarded and done_code is 2 (overflow).
- R8: If hpd_lost is high while busy, the transaction is abandoned. In the next cycle done is high with done_code 3 (disconnect), and tx_valid is low.
- R9: A start pulse while busy is ignored, and the ongoing transmission continues unchanged.
- R10: A length above MAX_LEN (16) is treated as MAX_LEN, for both the length byte and the payload count.
- R11: After reset, busy, tx_valid, out_valid and done are all low.
- R12: done is a single-cycle pulse, given once per transaction, in the cycle after the end of the reply or after the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch request fields and begin (ignored while busy) |
| cmd | input | 4 | Command nibble |
| addr | input | 20 | Target address |
| len | input | 5 | Request length in bytes, 0 = address only |
| wr_data | input | 128 | Write payload, byte i at bits 8*i+7:8*i |
| hpd_lost | input | 1 | Sink disconnect indication, aborts the transaction |
| busy | output | 1 | Transaction in progress |
| tx_valid | output | 1 | Request byte valid |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Request byte |
| rx_valid | input | 1 | Reply byte strobe |
| rx_data | input | 8 | Reply byte |
| rx_end | input | 1 | End of reply (may coincide with the last byte) |
| out_valid | output | 1 | Forwarded data byte valid |
| out_data | output | 8 | Forwarded data byte |
| reply_status | output | 4 | Status nibble of the reply |
| done | output | 1 | Completion pulse |
| done_code | output | 2 | 0 OK, 1 invalid reply, 2 overflow, 3 disconnect |

## Verification
A request byte counts as sent at the rising edge where tx_valid and tx_ready are both high. The bench samples on the preceding falling edge and pops the expected byte there, so each header and payload byte is compared in the cycle it moves. A forwarded reply byte appears one cycle after the edge that captured it. done and done_code appear one cycle after the edge that sees rx_end, or one cycle after hpd_lost. The monitor therefore compares out_data and the completion record at the falling edge after those edges. It drains the data queue before it checks done, because the last data byte and done can share a cycle.

// File: rtl/aux_xact_pkg.sv
// Shared types for the AUX transaction engine: controller states,
// completion codes and the command classification used by the framer.
package aux_xact_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2
    } xact_state_t;

    typedef enum logic [1:0] {
        DC_OK       = 2'd0,
        DC_INVALID  = 2'd1,
        DC_OVERFLOW = 2'd2,
        DC_DISCON   = 2'd3
    } done_code_t;

    // A command carries a payload only for native write, I2C write and
    // I2C write with the transaction kept open.
    function automatic logic cmd_is_write(input logic [3:0] c);
        return (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
    endfunction

endpackage

// File: rtl/aux_req_framer.sv
// Request framer: walks a byte index over header then payload and
// presents each byte on a valid/ready interface.
// Assumes the request fields stay stable while active (the controller
// latches them) and that load never arrives while active.
module aux_req_framer #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 abort,
    input  logic [3:0]           cmd,
    input  logic [19:0]          addr,
    input  logic [LEN_W-1:0]     len,
    input  logic [MAX_LEN*8-1:0] payload,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    output logic                 sent
);
    import aux_xact_pkg::*;

    localparam int IW = LEN_W + 1;

    logic          active;
    logic [IW-1:0] idx;
    logic [IW-1:0] total;
    logic [IW-1:0] pidx;
    logic          fire;

    // Number of bytes in this request: header plus payload for writes.
    always_comb begin
        total = (len != '0) ? IW'(4) : IW'(3);
        if (cmd_is_write(cmd))
            total = total + IW'(len);
    end

    assign fire     = active && tx_ready;
    assign sent     = fire && (idx == total - IW'(1));
    assign tx_valid = active;
    assign pidx     = idx - IW'(4);

    // Byte index and activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (abort) begin
            active <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (fire) begin
            idx <= idx + IW'(1);
            if (sent)
                active <= 1'b0;
        end
    end

    // Byte selection for the current index.
    always_comb begin
        case (idx)
            IW'(0):  tx_data = {cmd, addr[19:16]};
            IW'(1):  tx_data = addr[15:8];
            IW'(2):  tx_data = addr[7:0];
            IW'(3):  tx_data = (len != '0) ? 8'(len - LEN_W'(1)) : payload[7:0];
            default: tx_data = payload[{pidx, 3'b000} +: 8];
        endcase
    end

    // R4: a stalled byte is held until accepted
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tx_ready && !abort) |=> (active && $stable(tx_data)));

endmodule

// File: rtl/aux_reply_parser.sv
// Reply parser: takes the status nibble from the first reply byte,
// forwards ACK data bytes up to the request length and grades the
// end of the reply. Assumes clear pulses at the start of each request.
module aux_reply_parser #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [LEN_W-1:0] req_len,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_end,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic [3:0]       reply_status,
    output logic             fin,
    output logic [1:0]       fin_code
);
    import aux_xact_pkg::*;

    localparam int CW = LEN_W + 1;

    logic [CW-1:0] cnt;
    logic          ovf;
    logic [3:0]    status_q;
    logic          byte_in;
    logic          data_byte;
    logic          excess;

    assign byte_in   = en && rx_valid;
    assign data_byte = byte_in && (cnt != '0) && (status_q == 4'h0);
    assign excess    = data_byte && (cnt > {1'b0, req_len});

    // Byte counting, status capture and data forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            ovf       <= 1'b0;
            status_q  <= 4'h0;
            out_valid <= 1'b0;
            out_data  <= 8'h00;
        end else if (clear) begin
            cnt       <= '0;
            ovf       <= 1'b0;
            status_q  <= 4'h0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (byte_in) begin
                if (cnt == '0)
                    status_q <= rx_data[7:4];
                if (cnt != '1)
                    cnt <= cnt + CW'(1);
                if (data_byte && !excess) begin
                    out_valid <= 1'b1;
                    out_data  <= rx_data;
                end
                if (excess)
                    ovf <= 1'b1;
            end
        end
    end

    assign reply_status = status_q;
    assign fin          = en && rx_end;

    // Grade the reply at its end, counting a byte that shares the cycle.
    always_comb begin
        if ((cnt == '0) && !byte_in)
            fin_code = DC_INVALID;
        else if (ovf || excess)
            fin_code = DC_OVERFLOW;
        else
            fin_code = DC_OK;
    end

    // Count of bytes forwarded since the request began, for the bound check.
    logic [CW-1:0] fwd_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            fwd_cnt <= '0;
        else if (out_valid && fwd_cnt != '1)
            fwd_cnt <= fwd_cnt + CW'(1);
    end

    // R7: never more data bytes forwarded than requested
    p_fwd_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_cnt <= {1'b0, req_len});

endmodule

// File: rtl/aux_xact_engine.sv
// AUX transaction engine top: latches a request on start, lets the
// framer send it, then lets the parser consume the reply, and issues
// one done pulse with a completion code. A disconnect aborts at once.
// Assumes the receiver only presents reply bytes after the request.
module aux_xact_engine #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           cmd,
    input  logic [19:0]          addr,
    input  logic [LEN_W-1:0]     len,
    input  logic [MAX_LEN*8-1:0] wr_data,
    input  logic                 hpd_lost,
    output logic                 busy,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_end,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic [3:0]           reply_status,
    output logic                 done,
    output logic [1:0]           done_code
);
    import aux_xact_pkg::*;

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    xact_state_t          state;
    logic [3:0]           cmd_q;
    logic [19:0]          addr_q;
    logic [LEN_W-1:0]     len_q;
    logic [MAX_LEN*8-1:0] data_q;
    logic                 start_ok;
    logic                 sent;
    logic                 fin;
    logic [1:0]           fin_code;

    assign start_ok = start && (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);

    // Transaction sequencing, request latching and completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd_q     <= 4'h0;
            addr_q    <= '0;
            len_q     <= '0;
            data_q    <= '0;
            done      <= 1'b0;
            done_code <= DC_OK;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start_ok) begin
                    cmd_q  <= cmd;
                    addr_q <= addr;
                    len_q  <= (len > LEN_CAP) ? LEN_CAP : len;
                    data_q <= wr_data;
                    state  <= ST_SEND;
                end
                ST_SEND: if (hpd_lost) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    done_code <= DC_DISCON;
                end else if (sent) begin
                    state <= ST_RECV;
                end
                ST_RECV: if (hpd_lost) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    done_code <= DC_DISCON;
                end else if (fin) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    done_code <= fin_code;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    aux_req_framer #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .abort    (hpd_lost && (state == ST_SEND)),
        .cmd      (cmd_q),
        .addr     (addr_q),
        .len      (len_q),
        .payload  (data_q),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .sent     (sent)
    );

    aux_reply_parser #(.LEN_W(LEN_W)) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start_ok),
        .en           ((state == ST_RECV) && !hpd_lost),
        .req_len      (len_q),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_end       (rx_end),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .reply_status (reply_status),
        .fin          (fin),
        .fin_code     (fin_code)
    );

    // R8: disconnect while busy ends the transaction with code 3
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hpd_lost) |=> (done && done_code == DC_DISCON && !tx_valid));

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: start during a transaction leaves the latched request alone
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(len_q)));

endmodule

// File: tb/aux_xact_engine_bench.sv
// Scoreboard bench: driver tasks queue the expected request bytes, data
// bytes and completion; a falling-edge monitor pops and compares them.
module aux_xact_engine_bench;
    localparam int MAX_LEN = 16;
    localparam int LEN_W   = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [3:0]           cmd = 4'h0;
    logic [19:0]          addr = '0;
    logic [LEN_W-1:0]     len = '0;
    logic [MAX_LEN*8-1:0] wr_data = '0;
    logic                 hpd_lost = 1'b0;
    logic                 busy, tx_valid, out_valid, done;
    logic                 tx_ready;
    logic [7:0]           tx_data, out_data;
    logic                 rx_valid = 1'b0;
    logic [7:0]           rx_data = 8'h00;
    logic                 rx_end = 1'b0;
    logic [3:0]           reply_status;
    logic [1:0]           done_code;

    aux_xact_engine #(.MAX_LEN(MAX_LEN)) u_aux_xact_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .len(len), .wr_data(wr_data), .hpd_lost(hpd_lost), .busy(busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .out_valid(out_valid), .out_data(out_data),
        .reply_status(reply_status), .done(done), .done_code(done_code)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int ready_mode = 0;   // 0 always ready, 1 pattern, 2 never
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] exp_tx[$];
    logic [7:0] exp_out[$];
    logic [7:0] rep[$];
    logic [7:0] pl[MAX_LEN];
    int         cur_len;
    logic [1:0] exp_code;
    logic [3:0] exp_stat;
    bit         chk_stat;
    bit         exp_done = 1'b0;
    int         done_seen = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Ready pattern for the serializer side.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        tx_ready = (ready_mode == 0) ? 1'b1 :
                   (ready_mode == 1) ? (cyc % 3 == 0) : 1'b0;
    end

    // Monitor: compares sent bytes, forwarded bytes and completion.
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && tx_valid)
                check(tx_data == prev_data, "R4 held byte", tx_data, prev_data);
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0)
                    check(1'b0, "R1/R2/R3 extra byte", tx_data, 0);
                else
                    check(tx_data == exp_tx[0], "R1/R2/R3 byte", tx_data, exp_tx[0]);
                if (exp_tx.size() != 0) void'(exp_tx.pop_front());
            end
            if (out_valid) begin
                if (exp_out.size() == 0)
                    check(1'b0, "R5/R7 extra data", out_data, 0);
                else begin
                    check(out_data == exp_out[0], "R5 data", out_data, exp_out[0]);
                    void'(exp_out.pop_front());
                end
            end
            if (done) begin
                check(exp_done, "R12 unexpected done", 1, 0);
                check(done_code == exp_code, "R6/R7/R8 code", done_code, exp_code);
                check(exp_out.size() == 0, "R5 missing data", exp_out.size(), 0);
                if (chk_stat)
                    check(reply_status == exp_stat, "R5 status", reply_status, exp_stat);
                if (exp_code == 2'd3)
                    check(!tx_valid, "R8 tx stopped", tx_valid, 0);
                exp_done = 1'b0;
                done_seen++;
            end
        end
    end

    function automatic bit is_wr(input logic [3:0] c);
        return c == 4'h8 || c == 4'h0 || c == 4'h4;
    endfunction

    // Driver: queue the expected request stream and pulse start.
    task automatic send_req(input logic [3:0] c, input logic [19:0] a, input int l);
        int el;
        el = (l > MAX_LEN) ? MAX_LEN : l;
        cur_len = el;
        exp_tx.push_back({c, a[19:16]});
        exp_tx.push_back(a[15:8]);
        exp_tx.push_back(a[7:0]);
        if (el != 0) exp_tx.push_back(8'(el - 1));
        if (is_wr(c))
            for (int i = 0; i < el; i++) exp_tx.push_back(pl[i]);
        for (int i = 0; i < MAX_LEN; i++) wr_data[8*i +: 8] = pl[i];
        @(posedge clk); #1;
        cmd = c; addr = a; len = LEN_W'(l); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_tx_drain;
        do @(negedge clk); while (exp_tx.size() != 0);
    endtask

    // Driver: queue the expected reply results and drive the reply bytes.
    task automatic send_reply;
        int n;
        int nd;
        n = rep.size();
        chk_stat = (n != 0);
        exp_stat = (n != 0) ? rep[0][7:4] : 4'h0;
        nd = (n > 0) ? n - 1 : 0;
        if (n == 0) exp_code = 2'd1;
        else if (exp_stat == 4'h0 && nd > cur_len) exp_code = 2'd2;
        else exp_code = 2'd0;
        if (n > 0 && exp_stat == 4'h0)
            for (int i = 1; i < n && i <= cur_len; i++) exp_out.push_back(rep[i]);
        exp_done = 1'b1;
        if (n == 0) begin
            @(posedge clk); #1; rx_end = 1'b1;
        end
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_data = rep[i]; rx_end = (i == n - 1);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_end = 1'b0;
    endtask

    task automatic wait_done;
        int s;
        s = done_seen;
        while (done_seen == s) @(negedge clk);
        repeat (2) @(negedge clk);
        check(done_seen == s + 1, "R12 single done", done_seen - s, 1);
    endtask

    task automatic xact(input logic [3:0] c, input logic [19:0] a, input int l);
        send_req(c, a, l);
        wait_tx_drain();
        send_reply();
        wait_done();
        rep.delete();
    endtask

    initial begin
        for (int i = 0; i < MAX_LEN; i++) pl[i] = 8'(8'h30 + 7 * i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: quiet after reset
        check(!busy && !tx_valid && !out_valid && !done, "R11 reset", {busy, tx_valid, out_valid, done}, 0);

        // R1 R2 R5: native read, ACK with four bytes
        rep = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44};
        xact(4'h9, 20'hA5C3E, 4);

        // R3 R4: native write with a stalling serializer
        ready_mode = 1;
        rep = '{8'h00};
        xact(4'h8, 20'h00102, 3);
        ready_mode = 0;

        // R2: address-only write with transaction kept open
        rep = '{8'h00};
        xact(4'h4, 20'h00050, 0);

        // R3: I2C write with payload
        rep = '{8'h00};
        xact(4'h0, 20'h00051, 2);

        // R5: I2C read answered with NACK, nothing forwarded
        rep = '{8'h10, 8'hEE};
        xact(4'h5, 20'h00050, 2);

        // R3: status-request command sends no payload
        rep = '{8'h00, 8'h5A};
        xact(4'h2, 20'h00050, 1);

        // R6: empty reply
        rep.delete();
        xact(4'h9, 20'h00200, 1);

        // R7: ACK with too many data bytes
        rep = '{8'h00, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
        xact(4'h9, 20'h00300, 2);

        // R10: length above the cap, write
        rep = '{8'h00};
        xact(4'h8, 20'hFFFFF, 20);

        // R9: start while busy is ignored
        ready_mode = 2;
        send_req(4'h9, 20'h12345, 1);
        repeat (3) @(posedge clk);
        #1 cmd = 4'h8; addr = 20'h54321; len = 5'd3; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        ready_mode = 0;
        wait_tx_drain();
        rep = '{8'h00, 8'h77};
        send_reply();
        wait_done();
        rep.delete();

        // R8: disconnect during request transmission
        ready_mode = 2;
        send_req(4'h9, 20'h00400, 4);
        repeat (2) @(posedge clk);
        #1 exp_code = 2'd3; chk_stat = 1'b0; exp_done = 1'b1; hpd_lost = 1'b1;
        @(posedge clk); #1 hpd_lost = 1'b0;
        wait_done();
        exp_tx.delete();
        ready_mode = 0;

        // R8: disconnect while waiting for the reply
        send_req(4'h9, 20'h00500, 2);
        wait_tx_drain();
        @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'h00;
        @(posedge clk); #1 rx_valid = 1'b0;
        exp_code = 2'd3; chk_stat = 1'b0; exp_done = 1'b1; hpd_lost = 1'b1;
        @(posedge clk); #1 hpd_lost = 1'b0;
        wait_done();
        check(!busy, "R8 idle after abort", busy, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule